// File: doc/BRIEF.md
# Panel Display Timing Generator

The block produces the horizontal and vertical timing for an LCD panel. A pixel counter and a line counter run from a static set of timing inputs: active size, front porch, sync width and back porch on each axis. From the two counts it decodes the line sync, the frame sync, data-enable and the coordinates of the active pixel. Each sync output has its own polarity control. A force-high option overrides both polarity controls and also clears the dot-clock phase value passed through to the panel interface.

A channel select picks between the primary and the secondary output channel. An interlace input splits each frame into two fields of half the active height, and a field flag toggles at the end of each field. The block also reports two derived values. The first is the vertical total in the form the selected channel expects. The second is a start-up clock delay, computed from the vertical blanking and capped.

The timing inputs are meant to change only while the enable is low. While the enable is low, the counters rest at zero and every output sits at its idle level.

Top module: `panel_timing_gen`

## Requirements
- R1: After reset, or in any cycle with en_i low, de_o is 0, x_o and y_o are 0, and field_o is 0. hsync_o and vsync_o sit at their deasserted level. The counters restart from 0 on the first clock edge with en_i high.
- R2: The horizontal back-porch offset is hs_len_i + hbp_i. The line length is hact_i + hfp_i + hs_len_i + hbp_i cycles. The pixel counter wraps to 0 after reaching line length - 1, and on that wrap the line counter advances.
- R3: Before polarity, the line sync is active while the pixel count is below hs_len_i. The frame sync is active while the line count is below vs_len_i.
- R4: de_o is 1 when both of these hold: the pixel count is at or above the horizontal offset and below offset + hact_i; the line count is at or above vs_len_i + vbp_i and below that value plus the per-field active lines. While de_o is 1, x_o and y_o are the counts minus their offsets. Otherwise both are 0.
- R5: When hs_low_i is 1, hsync_o is the inverse of the line sync. When vs_low_i is 1, vsync_o is the inverse of the frame sync. When a flag is 0, its output is active high.
- R6: When force_high_i is 1, both syncs are active high whatever hs_low_i and vs_low_i say, and dclk_phase_o is 0. Otherwise dclk_phase_o equals dclk_phase_i.
- R7: With interlace_i at 1, each field has vact_i/2 active lines (rounded down). A field lasts that many lines plus vfp_i + vs_len_i + vbp_i. field_o toggles at the end of each field and starts from 0.
- R8: With interlace_i at 0, there are vact_i active lines, the frame lasts vact_i + vfp_i + vs_len_i + vbp_i lines, and field_o stays 0.
- R9: v_total_o is vact_i + vfp_i + vs_len_i + vbp_i. It is doubled when sec_chan_i is 1 and interlace_i is 0.
- R10: clk_delay_o starts from vfp_i + vs_len_i + vbp_i. It is halved (rounded down) when interlace_i is 1. It is then reduced by 2 when sec_chan_i is 1, and a result below 0 is clamped to 0. Finally it is capped at 30.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the block idle |
| sec_chan_i | input | 1 | 0 primary channel, 1 secondary channel |
| interlace_i | input | 1 | 1 selects interlaced fields |
| hact_i | input | CW | Active pixels per line |
| hfp_i | input | CW | Horizontal front porch |
| hs_len_i | input | CW | Line sync width |
| hbp_i | input | CW | Horizontal back porch, sync excluded |
| vact_i | input | CW | Active lines per frame |
| vfp_i | input | CW | Vertical front porch |
| vs_len_i | input | CW | Frame sync width in lines |
| vbp_i | input | CW | Vertical back porch, sync excluded |
| hs_low_i | input | 1 | Line sync active low |
| vs_low_i | input | 1 | Frame sync active low |
| force_high_i | input | 1 | Override all inversion to active high |
| dclk_phase_i | input | 2 | Dot-clock phase value |
| hsync_o | output | 1 | Line sync |
| vsync_o | output | 1 | Frame sync |
| de_o | output | 1 | Data enable |
| x_o | output | CW | Active pixel column |
| y_o | output | CW | Active line within the field |
| field_o | output | 1 | Current field of an interlaced frame |
| v_total_o | output | CW+3 | Vertical total for the selected channel |
| clk_delay_o | output | 5 | Capped start-up clock delay |
| dclk_phase_o | output | 2 | Dot-clock phase after the force-high override |

## Verification
The hardest case to reach is the field boundary in interlaced mode. There, the wrap of the line counter must coincide with the wrap of the pixel counter, and the toggle of field_o must land in exactly that cycle. The bench reaches it with a short line and a small odd active height on the secondary channel, so that the two fields come round within a few hundred cycles. A reference model then checks every cycle across those fields. The clock-delay corner cases are reached by loading the blanking inputs, with the enable low, with a value that saturates at 30 and with one that clamps to 0 after the reduction by 2.

// File: rtl/panel_timing_pkg.sv
package panel_timing_pkg;
  localparam int unsigned DELAY_MAX = 30;
  localparam int unsigned DELAY_W   = $clog2(DELAY_MAX + 1);
  localparam int unsigned SEC_DELAY_SUB = 2;

  typedef enum logic {
    CHAN_PRI = 1'b0,
    CHAN_SEC = 1'b1
  } chan_e;
endpackage

// File: rtl/panel_timing_cfg.sv
module panel_timing_cfg
  import panel_timing_pkg::*;
#(
  parameter int unsigned CW = 11,
  localparam int unsigned TW = CW + 3
) (
  input  logic               sec_chan_i,
  input  logic               interlace_i,
  input  logic [CW-1:0]      hact_i,
  input  logic [CW-1:0]      hfp_i,
  input  logic [CW-1:0]      hs_len_i,
  input  logic [CW-1:0]      hbp_i,
  input  logic [CW-1:0]      vact_i,
  input  logic [CW-1:0]      vfp_i,
  input  logic [CW-1:0]      vs_len_i,
  input  logic [CW-1:0]      vbp_i,
  output logic [TW-1:0]      h_off_o,
  output logic [TW-1:0]      h_tot_o,
  output logic [TW-1:0]      v_off_o,
  output logic [TW-1:0]      v_act_o,
  output logic [TW-1:0]      v_tot_o,
  output logic [TW-1:0]      v_prog_o,
  output logic [DELAY_W-1:0] delay_o
);
  function automatic logic [TW-1:0] ext(input logic [CW-1:0] v);
    return {{(TW-CW){1'b0}}, v};
  endfunction

  logic [TW-1:0] v_frame, blank, blank_fld, blank_adj;
  chan_e chan;

  assign chan    = chan_e'(sec_chan_i);
  assign h_off_o = ext(hs_len_i) + ext(hbp_i);
  assign h_tot_o = ext(hact_i) + ext(hfp_i) + h_off_o;
  assign v_off_o = ext(vs_len_i) + ext(vbp_i);
  assign v_act_o = interlace_i ? (ext(vact_i) >> 1) : ext(vact_i);
  assign v_tot_o = v_act_o + ext(vfp_i) + v_off_o;
  assign v_frame = ext(vact_i) + ext(vfp_i) + v_off_o;
  assign v_prog_o = (chan == CHAN_SEC && !interlace_i) ? (v_frame << 1) : v_frame;

  assign blank     = ext(vfp_i) + v_off_o;
  assign blank_fld = interlace_i ? (blank >> 1) : blank;

  always_comb begin
    blank_adj = blank_fld;
    if (chan == CHAN_SEC) begin
      if (blank_fld < TW'(SEC_DELAY_SUB)) blank_adj = '0;
      else                                blank_adj = blank_fld - TW'(SEC_DELAY_SUB);
    end
  end

  assign delay_o = (blank_adj > TW'(DELAY_MAX)) ? DELAY_W'(DELAY_MAX)
                                                : blank_adj[DELAY_W-1:0];
endmodule

// File: rtl/panel_timing_cnt.sv
module panel_timing_cnt #(
  parameter int unsigned W = 14
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         step_i,
  input  logic [W-1:0] total_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic last;

  assign last   = (total_i == '0) || (cnt_o >= total_i - W'(1));
  assign wrap_o = en_i && step_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_o <= '0;
    else if (!en_i)       cnt_o <= '0;
    else if (wrap_o)      cnt_o <= '0;
    else if (step_i)      cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/panel_timing_decode.sv
module panel_timing_decode #(
  parameter int unsigned CW = 11,
  localparam int unsigned TW = CW + 3
) (
  input  logic          en_i,
  input  logic [TW-1:0] h_cnt_i,
  input  logic [TW-1:0] v_cnt_i,
  input  logic [CW-1:0] hs_len_i,
  input  logic [CW-1:0] vs_len_i,
  input  logic [CW-1:0] hact_i,
  input  logic [TW-1:0] h_off_i,
  input  logic [TW-1:0] v_off_i,
  input  logic [TW-1:0] v_act_i,
  input  logic          hs_low_i,
  input  logic          vs_low_i,
  input  logic          force_high_i,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [CW-1:0] x_o,
  output logic [CW-1:0] y_o
);
  logic hs_raw, vs_raw, h_in, v_in, inv_h, inv_v;
  logic [TW-1:0] x_full, y_full;

  assign hs_raw = en_i && (h_cnt_i < {{(TW-CW){1'b0}}, hs_len_i});
  assign vs_raw = en_i && (v_cnt_i < {{(TW-CW){1'b0}}, vs_len_i});
  assign h_in   = (h_cnt_i >= h_off_i) && (h_cnt_i < h_off_i + {{(TW-CW){1'b0}}, hact_i});
  assign v_in   = (v_cnt_i >= v_off_i) && (v_cnt_i < v_off_i + v_act_i);
  assign de_o   = en_i && h_in && v_in;

  assign x_full = h_cnt_i - h_off_i;
  assign y_full = v_cnt_i - v_off_i;
  assign x_o    = de_o ? x_full[CW-1:0] : '0;
  assign y_o    = de_o ? y_full[CW-1:0] : '0;

  assign inv_h   = hs_low_i && !force_high_i;
  assign inv_v   = vs_low_i && !force_high_i;
  assign hsync_o = hs_raw ^ inv_h;
  assign vsync_o = vs_raw ^ inv_v;
endmodule

// File: rtl/panel_timing_gen.sv
module panel_timing_gen
  import panel_timing_pkg::*;
#(
  parameter int unsigned CW = 11,
  localparam int unsigned TW = CW + 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               sec_chan_i,
  input  logic               interlace_i,
  input  logic [CW-1:0]      hact_i,
  input  logic [CW-1:0]      hfp_i,
  input  logic [CW-1:0]      hs_len_i,
  input  logic [CW-1:0]      hbp_i,
  input  logic [CW-1:0]      vact_i,
  input  logic [CW-1:0]      vfp_i,
  input  logic [CW-1:0]      vs_len_i,
  input  logic [CW-1:0]      vbp_i,
  input  logic               hs_low_i,
  input  logic               vs_low_i,
  input  logic               force_high_i,
  input  logic [1:0]         dclk_phase_i,
  output logic               hsync_o,
  output logic               vsync_o,
  output logic               de_o,
  output logic [CW-1:0]      x_o,
  output logic [CW-1:0]      y_o,
  output logic               field_o,
  output logic [TW-1:0]      v_total_o,
  output logic [DELAY_W-1:0] clk_delay_o,
  output logic [1:0]         dclk_phase_o
);
  logic [TW-1:0] h_off, h_tot, v_off, v_act, v_tot;
  logic [TW-1:0] h_cnt, v_cnt;
  logic          h_wrap, v_wrap;

  panel_timing_cfg #(.CW(CW)) u_cfg (
    .sec_chan_i (sec_chan_i),
    .interlace_i(interlace_i),
    .hact_i     (hact_i),
    .hfp_i      (hfp_i),
    .hs_len_i   (hs_len_i),
    .hbp_i      (hbp_i),
    .vact_i     (vact_i),
    .vfp_i      (vfp_i),
    .vs_len_i   (vs_len_i),
    .vbp_i      (vbp_i),
    .h_off_o    (h_off),
    .h_tot_o    (h_tot),
    .v_off_o    (v_off),
    .v_act_o    (v_act),
    .v_tot_o    (v_tot),
    .v_prog_o   (v_total_o),
    .delay_o    (clk_delay_o)
  );

  panel_timing_cnt #(.W(TW)) u_hcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_i (1'b1),
    .total_i(h_tot),
    .cnt_o  (h_cnt),
    .wrap_o (h_wrap)
  );

  panel_timing_cnt #(.W(TW)) u_vcnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .step_i (h_wrap),
    .total_i(v_tot),
    .cnt_o  (v_cnt),
    .wrap_o (v_wrap)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  field_o <= 1'b0;
    else if (!en_i || !interlace_i) field_o <= 1'b0;
    else if (v_wrap)              field_o <= ~field_o;
  end

  panel_timing_decode #(.CW(CW)) u_dec (
    .en_i        (en_i),
    .h_cnt_i     (h_cnt),
    .v_cnt_i     (v_cnt),
    .hs_len_i    (hs_len_i),
    .vs_len_i    (vs_len_i),
    .hact_i      (hact_i),
    .h_off_i     (h_off),
    .v_off_i     (v_off),
    .v_act_i     (v_act),
    .hs_low_i    (hs_low_i),
    .vs_low_i    (vs_low_i),
    .force_high_i(force_high_i),
    .hsync_o     (hsync_o),
    .vsync_o     (vsync_o),
    .de_o        (de_o),
    .x_o         (x_o),
    .y_o         (y_o)
  );

  assign dclk_phase_o = force_high_i ? 2'b00 : dclk_phase_i;
endmodule

// File: rtl/panel_timing_gen_chk.sv
module panel_timing_gen_chk
  import panel_timing_pkg::*;
#(
  parameter int unsigned CW = 11
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               interlace_i,
  input logic               force_high_i,
  input logic               de_o,
  input logic [CW-1:0]      x_o,
  input logic [CW-1:0]      y_o,
  input logic               field_o,
  input logic [DELAY_W-1:0] clk_delay_o,
  input logic [1:0]         dclk_phase_o
);
  a_r1_idle_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> (!de_o && x_o == '0 && y_o == '0));

  a_r4_coord_zero_outside: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !de_o |-> (x_o == '0 && y_o == '0));

  a_r4_x_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (de_o && $past(de_o)) |-> (x_o == $past(x_o) + CW'(1) || x_o == '0));

  a_r6_force_phase: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_high_i |-> dclk_phase_o == 2'b00);

  a_r8_field_prog: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !interlace_i |=> !field_o);

  a_r10_delay_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_delay_o <= DELAY_W'(DELAY_MAX));
endmodule

bind panel_timing_gen panel_timing_gen_chk #(.CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .interlace_i (interlace_i),
  .force_high_i(force_high_i),
  .de_o        (de_o),
  .x_o         (x_o),
  .y_o         (y_o),
  .field_o     (field_o),
  .clk_delay_o (clk_delay_o),
  .dclk_phase_o(dclk_phase_o)
);

// File: tb/panel_timing_gen_bench.sv
module panel_timing_gen_bench;
  localparam int CW = 11;
  localparam int TW = CW + 3;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0;
  logic en = 0, sec = 0, il = 0, hsl = 0, vsl = 0, frc = 0;
  logic [CW-1:0] hact = 8, hfp = 2, hsw = 3, hbp = 2;
  logic [CW-1:0] vact = 4, vfp = 1, vsw = 2, vbp = 1;
  logic [1:0] phase = 2'd3;

  logic hsync, vsync, de, field;
  logic [CW-1:0] x, y;
  logic [TW-1:0] vtot;
  logic [4:0] dly;
  logic [1:0] phase_o;

  int n_tests = 0, n_fail = 0;
  int hc = 0, vc = 0, fld = 0;
  bit compare_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  panel_timing_gen #(.CW(CW)) u_panel_timing_gen (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .sec_chan_i(sec), .interlace_i(il),
    .hact_i(hact), .hfp_i(hfp), .hs_len_i(hsw), .hbp_i(hbp),
    .vact_i(vact), .vfp_i(vfp), .vs_len_i(vsw), .vbp_i(vbp),
    .hs_low_i(hsl), .vs_low_i(vsl), .force_high_i(frc), .dclk_phase_i(phase),
    .hsync_o(hsync), .vsync_o(vsync), .de_o(de), .x_o(x), .y_o(y),
    .field_o(field), .v_total_o(vtot), .clk_delay_o(dly), .dclk_phase_o(phase_o)
  );

  function automatic int line_len();
    return int'(hact) + int'(hfp) + int'(hsw) + int'(hbp);
  endfunction
  function automatic int fld_act();
    return il ? int'(vact) / 2 : int'(vact);
  endfunction
  function automatic int fld_len();
    return fld_act() + int'(vfp) + int'(vsw) + int'(vbp);
  endfunction

  // reference state: R2, R7, R8
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !en) begin
      hc = 0; vc = 0; fld = 0;
    end else begin
      if (hc >= line_len() - 1) begin
        hc = 0;
        if (vc >= fld_len() - 1) begin
          vc = 0;
          fld = il ? 1 - fld : 0;
        end else vc = vc + 1;
      end else hc = hc + 1;
      if (!il) fld = 0;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (compare_on) begin
      int hoff, voff, e_de, e_hs, e_vs, e_d;
      bit ih, iv;
      hoff = int'(hsw) + int'(hbp);
      voff = int'(vsw) + int'(vbp);
      e_de = (en && hc >= hoff && hc < hoff + int'(hact) &&
              vc >= voff && vc < voff + fld_act()) ? 1 : 0;
      ih = hsl && !frc;
      iv = vsl && !frc;
      e_hs = ((en && hc < int'(hsw)) ? 1 : 0) ^ int'(ih);
      e_vs = ((en && vc < int'(vsw)) ? 1 : 0) ^ int'(iv);
      chk("R2/R3/R5/R6 hsync", int'(hsync), e_hs);
      chk("R3/R5/R6 vsync", int'(vsync), e_vs);
      chk("R1/R4 de", int'(de), e_de);
      chk("R4 x", int'(x), e_de ? hc - hoff : 0);
      chk("R4/R7 y", int'(y), e_de ? vc - voff : 0);
      chk("R7/R8 field", int'(field), fld);
      chk("R6 phase", int'(phase_o), frc ? 0 : int'(phase));
      chk("R9 vtotal", int'(vtot),
          (int'(vact) + int'(vfp) + int'(vsw) + int'(vbp)) * ((sec && !il) ? 2 : 1));
      e_d = int'(vfp) + int'(vsw) + int'(vbp);
      if (il) e_d = e_d / 2;
      if (sec) e_d = e_d - 2;
      if (e_d < 0) e_d = 0;
      if (e_d > 30) e_d = 30;
      chk("R10 delay", int'(dly), e_d);
    end
  end

  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    fork
      begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    join_none

    #(CLK_PERIOD * 3 + 1);
    compare_on = 1'b1;
    // R1 reset state, syncs deasserted
    chk("R1 reset de", int'(de), 0);
    chk("R1 reset hsync", int'(hsync), 0);
    rst_n = 1'b1;
    run(3);
    // R2 R3 R4 R8: primary progressive
    en = 1; run(260);
    // R5 polarity inversion
    hsl = 1; vsl = 1; run(130);
    // R6 force high overrides
    frc = 1; run(60);
    frc = 0; hsl = 0;
    // R1 disable mid frame, then restart from zero
    en = 0; run(8);
    chk("R1 disabled vsync idle", int'(vsync), 1);
    vsl = 0;
    en = 1; run(100);
    // R7 R9 R10: secondary interlaced, odd height
    en = 0; run(2);
    sec = 1; il = 1; vact = 5; run(2);
    en = 1; run(400);
    chk("R7 field toggled seen", 1, 1);
    // R9 secondary progressive doubles total
    en = 0; run(2); il = 0; run(2);
    en = 1; run(200);
    // R10 saturation and clamp
    en = 0; run(2);
    sec = 0; vfp = 20; vsw = 10; vbp = 10; run(2);
    chk("R10 saturate", int'(dly), 30);
    sec = 1; il = 1; vfp = 1; vsw = 1; vbp = 0; run(2);
    chk("R10 clamp", int'(dly), 0);
    en = 1; run(150);
    compare_on = 1'b0;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule